// File: doc/BRIEF.md
# Oversampling Serial Receiver with Character Error Flags

This block turns an asynchronous serial line into parallel characters. It uses a sampling enable that pulses sixteen times per bit period. Each character has 5 to 8 data bits, sent least significant bit first. An optional even or odd parity bit may follow the data. Every finished character goes into a single holding register. The holding register also carries four status flags: line break, bad stop bit, parity mismatch and lost character (overrun).

The surrounding logic watches the ready flag and then pulses a read strobe to take the character. That read clears the ready flag and all four status flags. A separate error-reset pulse clears only the three flags that belong to a character. The overrun flag stays set, so a lost character is still visible after the per-character errors have been cleared. The line input must already be synchronous to the clock.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `rx_ready`, `rx_data` and all four status outputs are zero.
- R2: A low level on `rxd`, seen on an oversample tick while idle, begins a start bit. The start bit is confirmed only if `rxd` is still low on the 8th tick after that. If the line is high on that tick, the receiver returns to idle and produces no character.
- R3: The data-bit count is selected by `data_bits`: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Each data bit is sampled once, 16 ticks after the previous sample, least significant bit first. The character appears right-aligned on `rx_data`, with the unused upper bits set to zero.
- R4: When `par_en` is 1, one parity bit is sampled after the last data bit. `par_odd` = 0 selects even parity and 1 selects odd parity. If the data bits plus the parity bit do not match the selected parity, `st_parity` is set.
- R5: Only one stop sample is taken, 16 ticks after the last data or parity sample. A low level there sets `st_frame`. A high level is a valid stop.
- R6: `st_break` is set when every data bit, the parity bit (if enabled) and the stop sample are all zero. After such a low stop sample, no new start bit is accepted until the line has been high.
- R7: A finished character loads `rx_data` and sets `rx_ready`. This happens when the holding register is empty, or when it is being read in the same cycle.
- R8: If a character finishes while `rx_ready` is 1 and no read happens in that cycle, `st_overrun` is set. The new character is dropped, and `rx_data` and the other flags keep their values.
- R9: An `err_reset` pulse clears `st_break`, `st_frame` and `st_parity`. It leaves `st_overrun`, `rx_ready` and `rx_data` unchanged.
- R10: An `rd_strobe` pulse clears `rx_ready` and all four status flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial line, already synchronous to `clk` |
| os_tick | input | 1 | Oversample enable, 16 pulses per bit period |
| data_bits | input | 2 | Data-bit count select (0..3 gives 5..8 bits) |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| err_reset | input | 1 | Clear the break, framing and parity flags |
| rd_strobe | input | 1 | Take the held character and clear all flags |
| rx_data | output | 8 | Held character |
| rx_ready | output | 1 | The holding register holds an unread character |
| st_break | output | 1 | Break received |
| st_frame | output | 1 | Stop sample was low |
| st_parity | output | 1 | Parity mismatch |
| st_overrun | output | 1 | A character was lost |

## Verification
A character's result reaches the outputs two clock edges after the tick that samples its stop bit. The first edge registers the finished-character pulse in the sampler, and the second loads the holding register. The bench waits until the end of the stop bit, about half a bit period after that sample, and then reads the outputs on a falling clock edge, well clear of the load.

The effects of `err_reset` and `rd_strobe` appear one edge after the pulse. The bench checks them on the next falling edge. The false-start case is checked after a time in which a real character would already have loaded.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_PAR   = 3'd3,
    S_STOP  = 3'd4,
    S_HOLD  = 3'd5
  } rx_state_t;

  typedef struct packed {
    logic [7:0] data;
    logic       brk;
    logic       fe;
    logic       pe;
  } rx_char_t;

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE = 16,
  parameter int DATA_W  = 8,
  localparam int CNT_W  = $clog2(OS_RATE),
  localparam int IDX_W  = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rxd,
  input  logic             os_tick,
  input  logic [IDX_W-1:0] last_idx,
  input  logic             par_en,
  input  logic             par_odd,
  output logic             done,
  output rx_char_t         char_out
);

  localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OS_RATE / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OS_RATE - 1);

  rx_state_t         state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              pbit_q, pbit_d;
  logic              done_q, done_d;
  rx_char_t          char_q, char_d;

  logic              bit_point;
  logic [DATA_W-1:0] aligned;
  logic              par_err;

  assign bit_point = os_tick && (cnt_q == LAST_TICK);
  assign aligned   = sh_q >> (IDX_W'(DATA_W - 1) - last_idx);
  assign par_err   = par_en && ((^sh_q ^ pbit_q) != par_odd);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    pbit_d  = pbit_q;
    done_d  = 1'b0;
    char_d  = char_q;
    unique case (state_q)
      S_IDLE: begin
        if (os_tick && !rxd) begin
          state_d = S_START;
          cnt_d   = '0;
        end
      end
      S_START: begin
        if (os_tick) begin
          if (cnt_q == MID_TICK) begin
            cnt_d = '0;
            if (rxd) begin
              state_d = S_IDLE;
            end else begin
              state_d = S_DATA;
              idx_d   = '0;
              sh_d    = '0;
              pbit_d  = 1'b0;
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      S_DATA: begin
        if (os_tick) cnt_d = cnt_q + 1'b1;
        if (bit_point) begin
          cnt_d = '0;
          sh_d  = {rxd, sh_q[DATA_W-1:1]};
          idx_d = idx_q + 1'b1;
          if (idx_q == last_idx) state_d = par_en ? S_PAR : S_STOP;
        end
      end
      S_PAR: begin
        if (os_tick) cnt_d = cnt_q + 1'b1;
        if (bit_point) begin
          cnt_d   = '0;
          pbit_d  = rxd;
          state_d = S_STOP;
        end
      end
      S_STOP: begin
        if (os_tick) cnt_d = cnt_q + 1'b1;
        if (bit_point) begin
          cnt_d       = '0;
          done_d      = 1'b1;
          char_d.data = 8'(aligned);
          char_d.fe   = !rxd;
          char_d.pe   = par_err;
          char_d.brk  = (sh_q == '0) && !(par_en && pbit_q) && !rxd;
          state_d     = rxd ? S_IDLE : S_HOLD;
        end
      end
      S_HOLD: begin
        if (rxd) state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      pbit_q  <= 1'b0;
      done_q  <= 1'b0;
      char_q  <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      pbit_q  <= pbit_d;
      done_q  <= done_d;
      char_q  <= char_d;
    end
  end

  assign done     = done_q;
  assign char_out = char_q;

  // R2: a high line at the validation tick abandons the start bit
  p_false_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_START && os_tick && cnt_q == MID_TICK && rxd) |=> (state_q == S_IDLE));

  // R5: one stop sample gives exactly one single-cycle completion pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R6: after a low stop sample no start is accepted while the line stays low
  p_hold_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HOLD && !rxd) |=> (state_q == S_HOLD));

endmodule

// File: rtl/uart_rx_holdreg.sv
module uart_rx_holdreg
  import uart_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       done,
  input  rx_char_t   char_in,
  input  logic       err_reset,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       st_break,
  output logic       st_frame,
  output logic       st_parity,
  output logic       st_overrun
);

  logic [7:0] data_q, data_d;
  logic       rdy_q, rdy_d;
  logic       brk_q, brk_d;
  logic       fe_q, fe_d;
  logic       pe_q, pe_d;
  logic       ovr_q, ovr_d;
  logic       accept;

  assign accept = done && (!rdy_q || rd_strobe);

  always_comb begin
    data_d = data_q;
    rdy_d  = rdy_q;
    brk_d  = brk_q;
    fe_d   = fe_q;
    pe_d   = pe_q;
    ovr_d  = ovr_q;
    if (rd_strobe) begin
      rdy_d = 1'b0;
      brk_d = 1'b0;
      fe_d  = 1'b0;
      pe_d  = 1'b0;
      ovr_d = 1'b0;
    end
    if (err_reset) begin
      brk_d = 1'b0;
      fe_d  = 1'b0;
      pe_d  = 1'b0;
    end
    if (accept) begin
      data_d = char_in.data;
      rdy_d  = 1'b1;
      brk_d  = char_in.brk;
      fe_d   = char_in.fe;
      pe_d   = char_in.pe;
    end else if (done) begin
      ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy_q  <= 1'b0;
      brk_q  <= 1'b0;
      fe_q   <= 1'b0;
      pe_q   <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      rdy_q  <= rdy_d;
      brk_q  <= brk_d;
      fe_q   <= fe_d;
      pe_q   <= pe_d;
      ovr_q  <= ovr_d;
    end
  end

  assign rx_data    = data_q;
  assign rx_ready   = rdy_q;
  assign st_break   = brk_q;
  assign st_frame   = fe_q;
  assign st_parity  = pe_q;
  assign st_overrun = ovr_q;

  // R8: a dropped character leaves the held data alone and flags overrun
  p_drop_keeps_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && rdy_q && !rd_strobe) |=> ($stable(data_q) && ovr_q));

  // R9: error reset never touches the overrun flag
  p_errrst_keeps_ovr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (err_reset && !rd_strobe && ovr_q) |=> ovr_q);

  // R10: a read with no arriving character empties everything
  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !done) |=> (!rdy_q && !brk_q && !fe_q && !pe_q && !ovr_q));

  // R6: break can only come with a low stop sample
  p_brk_has_fe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk_q |-> fe_q);

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
  import uart_rx_pkg::*;
#(
  parameter int OS_RATE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rxd,
  input  logic       os_tick,
  input  logic [1:0] data_bits,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       err_reset,
  input  logic       rd_strobe,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       st_break,
  output logic       st_frame,
  output logic       st_parity,
  output logic       st_overrun
);

  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W);
  localparam int MIN_W  = 5;

  logic [IDX_W-1:0] last_idx;
  logic             done;
  rx_char_t         char_w;

  assign last_idx = IDX_W'(data_bits) + IDX_W'(MIN_W - 1);

  uart_rx_sampler #(
    .OS_RATE (OS_RATE),
    .DATA_W  (DATA_W)
  ) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .rxd      (rxd),
    .os_tick  (os_tick),
    .last_idx (last_idx),
    .par_en   (par_en),
    .par_odd  (par_odd),
    .done     (done),
    .char_out (char_w)
  );

  uart_rx_holdreg u_hold (
    .clk        (clk),
    .rst_n      (rst_n),
    .done       (done),
    .char_in    (char_w),
    .err_reset  (err_reset),
    .rd_strobe  (rd_strobe),
    .rx_data    (rx_data),
    .rx_ready   (rx_ready),
    .st_break   (st_break),
    .st_frame   (st_frame),
    .st_parity  (st_parity),
    .st_overrun (st_overrun)
  );

endmodule

// File: tb/uart_rx_status_bench.sv
module uart_rx_status_bench;
  localparam int CLK_PERIOD = 10;
  localparam int OSDIV      = 4;
  localparam int OSR        = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       os_tick = 1'b0;
  logic [1:0] data_bits = 2'd3;
  logic       par_en = 1'b0;
  logic       par_odd = 1'b0;
  logic       err_reset = 1'b0;
  logic       rd_strobe = 1'b0;
  logic [7:0] rx_data;
  logic       rx_ready, st_break, st_frame, st_parity, st_overrun;

  int checks = 0;
  int errors = 0;
  int divc = 0;

  uart_rx_status u_uart_rx_status (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .os_tick(os_tick),
    .data_bits(data_bits), .par_en(par_en), .par_odd(par_odd),
    .err_reset(err_reset), .rd_strobe(rd_strobe), .rx_data(rx_data),
    .rx_ready(rx_ready), .st_break(st_break), .st_frame(st_frame),
    .st_parity(st_parity), .st_overrun(st_overrun)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    divc    <= (divc == OSDIV-1) ? 0 : divc + 1;
    os_tick <= (divc == OSDIV-1);
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n*OSDIV) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int nb, input bit pon, input bit pbit, input bit stop_lvl);
    rxd = 1'b0; ticks(OSR);
    for (int i = 0; i < nb; i++) begin rxd = d[i]; ticks(OSR); end
    if (pon) begin rxd = pbit; ticks(OSR); end
    rxd = stop_lvl; ticks(OSR);
    rxd = 1'b1; ticks(4);
  endtask

  task automatic cfg(input int nb, input bit pon, input bit odd);
    data_bits = 2'(nb - 5); par_en = pon; par_odd = odd;
  endtask

  task automatic pulse_read();
    rd_strobe = 1'b1; @(negedge clk); rd_strobe = 1'b0; @(negedge clk);
  endtask

  task automatic pulse_errrst();
    err_reset = 1'b1; @(negedge clk); err_reset = 1'b0; @(negedge clk);
  endtask

  function automatic bit par_of(input logic [7:0] d, input int nb, input bit odd);
    logic [7:0] m = d & 8'((1 << nb) - 1);
    return (^m) ^ odd;
  endfunction

  function automatic int flags();
    return {28'd0, st_break, st_frame, st_parity, st_overrun};
  endfunction

  task automatic t_reset();
    check("R1 ready", rx_ready, 0);
    check("R1 data", rx_data, 0);
    check("R1 flags", flags(), 0);
  endtask

  task automatic t_eight_bits();
    cfg(8, 0, 0);
    send(8'hA5, 8, 0, 0, 1);
    check("R7 ready", rx_ready, 1);
    check("R3 data 8b", rx_data, 8'hA5);
    check("R5 clean stop flags", flags(), 0);
    pulse_read();
    check("R10 ready cleared", rx_ready, 0);
  endtask

  task automatic t_five_bits();
    cfg(5, 0, 0);
    send(8'hF5, 5, 0, 0, 1);
    check("R3 data 5b aligned", rx_data, 8'h15);
    pulse_read();
    cfg(6, 0, 0);
    send(8'h2B, 6, 0, 0, 1);
    check("R3 data 6b", rx_data, 8'h2B);
    pulse_read();
  endtask

  task automatic t_parity();
    cfg(7, 1, 0);
    send(8'h53, 7, 1, par_of(8'h53, 7, 0), 1);
    check("R4 even ok", {rx_data, st_parity}, {8'h53, 1'b0});
    pulse_read();
    send(8'h53, 7, 1, ~par_of(8'h53, 7, 0), 1);
    check("R4 even bad", st_parity, 1);
    pulse_read();
    cfg(8, 1, 1);
    send(8'h81, 8, 1, par_of(8'h81, 8, 1), 1);
    check("R4 odd ok", st_parity, 0);
    pulse_read();
    send(8'h81, 8, 1, ~par_of(8'h81, 8, 1), 1);
    check("R4 odd bad", st_parity, 1);
    check("R10 before read", rx_ready, 1);
    pulse_read();
    check("R10 parity cleared", st_parity, 0);
  endtask

  task automatic t_frame();
    cfg(8, 0, 0);
    send(8'h3C, 8, 0, 0, 0);
    check("R5 frame err", {st_frame, st_break}, 2'b10);
    check("R5 data kept", rx_data, 8'h3C);
    pulse_errrst();
    check("R9 frame cleared", st_frame, 0);
    check("R9 ready kept", rx_ready, 1);
    pulse_read();
  endtask

  task automatic t_break();
    cfg(8, 1, 0);
    rxd = 1'b0; ticks(OSR*14);
    check("R6 break", {st_break, st_frame}, 2'b11);
    check("R6 no repeat while low", st_overrun, 0);
    pulse_read();
    ticks(OSR*3);
    check("R6 held off while low", rx_ready, 0);
    rxd = 1'b1; ticks(OSR);
    send(8'h66, 8, 1, par_of(8'h66, 8, 0), 1);
    check("R6 recovers", {rx_data, 4'(flags())}, {8'h66, 4'h0});
    pulse_read();
  endtask

  task automatic t_overrun();
    cfg(8, 1, 0);
    send(8'h11, 8, 1, ~par_of(8'h11, 8, 0), 1);
    send(8'h22, 8, 1, par_of(8'h22, 8, 0), 1);
    check("R8 overrun", st_overrun, 1);
    check("R8 data kept", rx_data, 8'h11);
    check("R8 flags kept", st_parity, 1);
    pulse_errrst();
    check("R9 ovr kept", {st_overrun, st_parity}, 2'b10);
    pulse_read();
    check("R10 ovr cleared", {rx_ready, 4'(flags())}, 5'd0);
  endtask

  task automatic t_false_start();
    cfg(8, 0, 0);
    rxd = 1'b0; ticks(4); rxd = 1'b1;
    ticks(OSR*11);
    check("R2 glitch ignored", rx_ready, 0);
    send(8'h7E, 8, 0, 0, 1);
    check("R2 next char ok", rx_data, 8'h7E);
    pulse_read();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_eight_bits();
    t_five_bits();
    t_parity();
    t_frame();
    t_break();
    t_overrun();
    t_false_start();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired, run hung (all R)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule